// File: doc/BRIEF.md
# MSI Doorbell Write Decoder

This block sits behind a write-only memory window that PCI devices target with their message-signalled interrupt writes. Every device owns a 64 KiB sub-window, so the window spans the number of device slots times 0x10000 bytes. The address bits above bit 16 pick a device slot. The block forms a vector index from the word offset inside the sub-window and the low bits of the written data, adds the base interrupt number held for that slot, and emits a single-cycle pulse that carries the resulting interrupt number. A downstream interrupt controller consumes the pulse.

Both message styles travel through one path. The per-vector style puts vector i at sub-window offset i*4 and writes zero data. The single-address style always writes to offset 0 and places the vector in the data. The block ORs the two contributions together, so either style gives the right vector without a mode setting. A configuration port loads the per-slot base numbers. A read of the window carries no meaning: it returns zero and has no side effect. A doorbell that addresses a slot beyond the table is dropped and sets a sticky error flag.

Top module: `msi_doorbell_decoder`

## Requirements
- R1: After reset, irqValid is 0, irqNum is 0, errSticky is 0 and every slot base is 0.
- R2: The device slot of a doorbell is byte-address bits [ADDR_W-1:16], which is word-address bits [ADDR_W-3:14]. The pulse uses the base stored for that slot.
- R3: The vector is the sub-window word offset (byte-address bits [15:2], word-address bits [13:0]) bitwise ORed with wrData. Offset i with zero data and offset 0 with data i both give vector i.
- R4: When the clock edge samples wrValid high for an in-range slot, irqValid is high in the following cycle and irqNum equals (slot base + vector) modulo 2^IRQ_W.
- R5: Each accepted doorbell gives exactly one cycle of irqValid. Back-to-back doorbells give back-to-back pulses. irqValid is low in any cycle that follows an edge without an accepted doorbell.
- R6: A doorbell whose slot field is NUM_SLOTS or greater produces no pulse. It sets errSticky in the next cycle, and errSticky then stays set until reset.
- R7: cfgWe loads cfgBase into the slot named by cfgSlot. A cfgSlot of NUM_SLOTS or greater changes no base.
- R8: When a configuration load and a doorbell to the same slot are sampled on the same edge, the doorbell uses the base held before that edge. The new base applies to later doorbells.
- R9: rdData is always zero, and a read (rdEn) produces no pulse and no error.
- R10: irqNum keeps its last value in every cycle that carries no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Doorbell write strobe |
| wrWordAddr | input | ADDR_W-2 | Word address of the write within the window |
| wrData | input | DATA_W | Write data |
| rdEn | input | 1 | Read strobe on the window |
| rdData | output | DATA_W | Read data, always zero |
| cfgWe | input | 1 | Base table load strobe |
| cfgSlot | input | SLOT_W | Slot to load |
| cfgBase | input | IRQ_W | Base interrupt number to load |
| irqValid | output | 1 | One-cycle interrupt pulse |
| irqNum | output | IRQ_W | Interrupt number for the pulse |
| errSticky | output | 1 | Set by a doorbell to a slot outside the table |

## Verification
A base-table load and a doorbell can hit the same slot on the same clock edge, and the order in which they act decides which base the pulse carries. The bench provokes this by driving cfgWe and wrValid together for one slot with a new base. The behavioural model serves the doorbell from its stored bases before it applies the load, so the pulse must carry the old base, and the next doorbell to that slot must carry the new one. The bench also drives a dropped out-of-range doorbell on the same edge as a valid configuration load. The load must take effect, and the error flag must rise with no pulse.

// File: rtl/msi_db_pkg.sv
package msi_db_pkg;

  // Per-cycle strobes from the control decode to the datapath.
  typedef struct packed {
    logic fire;  // in-range doorbell accepted this cycle
    logic drop;  // doorbell addressed a slot beyond the table
    logic load;  // base table write to an in-range slot
  } dbStrobes_t;

  // Bit offset of the slot field within a word address (byte bit 16).
  localparam int SLOT_LSB_WORD = 14;
  // Width of the word offset inside one 64 KiB sub-window.
  localparam int OFS_W = 14;

endpackage

// File: rtl/msiDbCtrl.sv
module msiDbCtrl
  import msi_db_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int NUM_SLOTS = 6,
  parameter int SLOT_W    = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrValid,
  input  logic [ADDR_W-SLOT_LSB_WORD-3:0] wrSlotField,
  input  logic                          rdEn,
  input  logic                          cfgWe,
  input  logic [SLOT_W-1:0]             cfgSlot,
  output dbStrobes_t                    strobes,
  output logic                          errSticky
);

  localparam int FIELD_W = ADDR_W - SLOT_LSB_WORD - 2;

  logic wrInRange;
  logic cfgInRange;

  // Range checks: a power-of-two table fills its whole field.
  generate
    if (NUM_SLOTS == (1 << FIELD_W)) begin : g_wrFull
      assign wrInRange = 1'b1;
    end else begin : g_wrCmp
      assign wrInRange = (wrSlotField < FIELD_W'(NUM_SLOTS));
    end
    if (NUM_SLOTS == (1 << SLOT_W)) begin : g_cfgFull
      assign cfgInRange = 1'b1;
    end else begin : g_cfgCmp
      assign cfgInRange = (cfgSlot < SLOT_W'(NUM_SLOTS));
    end
  endgenerate

  always_comb begin
    strobes.fire = wrValid && wrInRange;
    strobes.drop = wrValid && !wrInRange;
    strobes.load = cfgWe && cfgInRange;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errSticky <= 1'b0;
    end else if (strobes.drop) begin
      errSticky <= 1'b1;
    end
  end

  // R6: a dropped doorbell raises the flag on the next cycle
  p_drop_flags_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrInRange) |=> errSticky);

  // R6: the flag never clears outside reset
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky);

  // R9: a read alone never counts as a dropped doorbell
  p_rd_noerr_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrValid && !errSticky) |=> !errSticky);

endmodule

// File: rtl/msiDbPath.sv
module msiDbPath
  import msi_db_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int IRQ_W     = 16,
  parameter int NUM_SLOTS = 6,
  parameter int SLOT_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dbStrobes_t        strobes,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [OFS_W-1:0]  wrOffset,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SLOT_W-1:0] cfgSlot,
  input  logic [IRQ_W-1:0]  cfgBase,
  output logic              irqValid,
  output logic [IRQ_W-1:0]  irqNum
);

  logic [IRQ_W-1:0] baseTab [NUM_SLOTS];
  logic [IRQ_W-1:0] selBase;
  logic [IRQ_W-1:0] vecAddr;
  logic [IRQ_W-1:0] vecData;
  logic [IRQ_W-1:0] vector;

  // One base register per slot.
  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rstN) begin
          baseTab[g] <= '0;
        end else if (strobes.load && (cfgSlot == SLOT_W'(g))) begin
          baseTab[g] <= cfgBase;
        end
      end
    end
  endgenerate

  // Slot select reads the table before any same-edge load.
  always_comb begin
    selBase = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (wrSlot == SLOT_W'(i)) selBase = baseTab[i];
    end
  end

  // Per-vector offset and single-address data both feed the vector.
  assign vecAddr = IRQ_W'(wrOffset);
  assign vecData = IRQ_W'(wrData);
  assign vector  = vecAddr | vecData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqValid <= 1'b0;
      irqNum   <= '0;
    end else begin
      irqValid <= strobes.fire;
      if (strobes.fire) irqNum <= selBase + vector;
    end
  end

  // R5: an accepted doorbell gives a pulse in the next cycle
  p_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fire |=> irqValid);

  // R5: no accepted doorbell, no pulse
  p_no_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.fire |=> !irqValid);

  // R10: the number is held while no pulse is issued
  p_hold_num_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.fire |=> $stable(irqNum));

endmodule

// File: rtl/msi_doorbell_decoder.sv
module msi_doorbell_decoder
  import msi_db_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int IRQ_W     = 16,
  parameter int NUM_SLOTS = 6,
  parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-3:0] wrWordAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              cfgWe,
  input  logic [SLOT_W-1:0] cfgSlot,
  input  logic [IRQ_W-1:0]  cfgBase,
  output logic              irqValid,
  output logic [IRQ_W-1:0]  irqNum,
  output logic              errSticky
);

  localparam int FIELD_W = ADDR_W - SLOT_LSB_WORD - 2;

  dbStrobes_t          strobes;
  logic [FIELD_W-1:0]  slotField;

  assign slotField = wrWordAddr[ADDR_W-3:SLOT_LSB_WORD];

  // The window has no readable content.
  assign rdData = '0;

  msiDbCtrl #(
    .ADDR_W    (ADDR_W),
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrValid     (wrValid),
    .wrSlotField (slotField),
    .rdEn        (rdEn),
    .cfgWe       (cfgWe),
    .cfgSlot     (cfgSlot),
    .strobes     (strobes),
    .errSticky   (errSticky)
  );

  msiDbPath #(
    .DATA_W    (DATA_W),
    .IRQ_W     (IRQ_W),
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrSlot   (slotField[SLOT_W-1:0]),
    .wrOffset (wrWordAddr[OFS_W-1:0]),
    .wrData   (wrData),
    .cfgSlot  (cfgSlot),
    .cfgBase  (cfgBase),
    .irqValid (irqValid),
    .irqNum   (irqNum)
  );

  // R9: a read with no write never yields a pulse
  p_rd_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrValid) |=> !irqValid);

endmodule

// File: tb/sim_msi_doorbell_decoder.sv
module sim_msi_doorbell_decoder;

  localparam int ADDR_W    = 20;
  localparam int DATA_W    = 16;
  localparam int IRQ_W     = 16;
  localparam int NUM_SLOTS = 6;
  localparam int SLOT_W    = 3;

  logic              clk = 1'b0;
  logic              rstN;
  logic              wrValid;
  logic [ADDR_W-3:0] wrWordAddr;
  logic [DATA_W-1:0] wrData;
  logic              rdEn;
  logic [DATA_W-1:0] rdData;
  logic              cfgWe;
  logic [SLOT_W-1:0] cfgSlot;
  logic [IRQ_W-1:0]  cfgBase;
  logic              irqValid;
  logic [IRQ_W-1:0]  irqNum;
  logic              errSticky;

  always #4 clk = ~clk;  // 125 MHz

  msi_doorbell_decoder #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_W(IRQ_W),
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)
  ) u0 (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrWordAddr(wrWordAddr),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .cfgWe(cfgWe),
    .cfgSlot(cfgSlot), .cfgBase(cfgBase), .irqValid(irqValid),
    .irqNum(irqNum), .errSticky(errSticky)
  );

  int    checks = 0;
  int    fails  = 0;
  string curReq = "R1";
  bit    done   = 1'b0;

  // Behavioural reference state
  int modelBase [NUM_SLOTS];
  bit expValid;
  int expNum;
  bit expErr;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (modelBase[i]) modelBase[i] = 0;
      expValid = 1'b0;
      expNum   = 0;
      expErr   = 1'b0;
    end else begin
      int sl;
      int vec;
      sl  = int'(wrWordAddr) >> 14;
      vec = (int'(wrWordAddr) & 'h3FFF) | int'(wrData);
      expValid = 1'b0;
      if (wrValid) begin
        if (sl < NUM_SLOTS) begin
          expValid = 1'b1;
          expNum   = (modelBase[sl] + vec) & 'hFFFF;
        end else begin
          expErr = 1'b1;
        end
      end
      if (cfgWe && int'(cfgSlot) < NUM_SLOTS) modelBase[cfgSlot] = int'(cfgBase);
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(irqValid == expValid, curReq, "irqValid", int'(irqValid), int'(expValid));
      check(int'(irqNum) == expNum, curReq, "irqNum", int'(irqNum), expNum);
      check(errSticky == expErr, curReq, "errSticky", int'(errSticky), int'(expErr));
      check(rdData == '0, "R9", "rdData", int'(rdData), 0);
    end
  end

  function automatic logic [ADDR_W-3:0] wordOf(int slot, int ofs);
    return (ADDR_W-2)'((slot << 14) | (ofs & 'h3FFF));
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic door(int slot, int ofs, int data);
    wrValid = 1'b1; wrWordAddr = wordOf(slot, ofs); wrData = DATA_W'(data);
    @(negedge clk);
    wrValid = 1'b0; wrWordAddr = '0; wrData = '0;
  endtask

  task automatic cfg(int slot, int base);
    cfgWe = 1'b1; cfgSlot = SLOT_W'(slot); cfgBase = IRQ_W'(base);
    @(negedge clk);
    cfgWe = 1'b0; cfgSlot = '0; cfgBase = '0;
  endtask

  task automatic both(int wslot, int ofs, int data, int cslot, int base);
    wrValid = 1'b1; wrWordAddr = wordOf(wslot, ofs); wrData = DATA_W'(data);
    cfgWe = 1'b1; cfgSlot = SLOT_W'(cslot); cfgBase = IRQ_W'(base);
    @(negedge clk);
    wrValid = 1'b0; wrWordAddr = '0; wrData = '0;
    cfgWe = 1'b0; cfgSlot = '0; cfgBase = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog (run hung) actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrValid = 1'b0; wrWordAddr = '0; wrData = '0;
    rdEn = 1'b0; cfgWe = 1'b0; cfgSlot = '0; cfgBase = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state, plus zero bases seen through a doorbell
    curReq = "R1";
    idle(2);
    door(2, 0, 0);
    idle(1);

    // R7: load every slot, then try an out-of-range load
    curReq = "R7";
    for (int s = 0; s < NUM_SLOTS; s++) cfg(s, 'h0100 * (s + 1) + s);
    cfg(6, 'hDEAD);
    cfg(7, 'hBEEF);
    for (int s = 0; s < NUM_SLOTS; s++) door(s, 0, 0);
    idle(1);

    // R2: per-vector style, slot chosen by the upper address field
    curReq = "R2";
    for (int s = 0; s < NUM_SLOTS; s++) door(s, s + 3, 0);
    idle(1);

    // R3: single-address style, data carries the vector; OR merge
    curReq = "R3";
    door(1, 0, 9);
    door(3, 5, 2);
    door(4, 'h2A5A, 'h5000);
    door(0, 'h3FFF, 0);
    idle(1);

    // R4: sum wraps modulo 2^16
    curReq = "R4";
    cfg(5, 'hFFF0);
    door(5, 'h20, 0);
    door(5, 0, 'hFFFF);
    idle(1);

    // R5: back-to-back pulses, then quiet cycles
    curReq = "R5";
    door(0, 1, 0);
    door(1, 2, 0);
    door(2, 3, 0);
    idle(3);

    // R10: number held over idle and read cycles
    curReq = "R10";
    idle(2);

    // R9: reads produce nothing
    curReq = "R9";
    rdEn = 1'b1;
    idle(3);
    rdEn = 1'b0;
    idle(1);

    // R8: same-edge load and doorbell to one slot
    curReq = "R8";
    both(3, 4, 0, 3, 'h0700);
    door(3, 4, 0);
    idle(1);

    // R6: out-of-range doorbells, alongside a valid load
    curReq = "R6";
    both(6, 1, 0, 2, 'h0333);
    idle(2);
    door(15, 0, 7);
    door(2, 1, 0);
    idle(3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule